// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This controller runs the entry and exit sequences of a 32-bit core's trap system. It handles hardware exceptions, external interrupts and the software commands that raise, leave or mask traps. On entry it copies the current instruction pointer, stack pointer and flags into three save registers. It then reads the handler address from a descriptor table at a fixed base address over a valid/ready read port. Finally it hands the core a new instruction pointer and flags with load strobes.

The return command reverses the entry: it gives back the three saved values with all three strobes. Two further commands set or clear the interrupt-enable flag. Privileged commands issued in user mode become a general-protection trap on vector 4. Each request source holds its request until the controller takes it. Taking a request raises `busy`. An entry also gives a one-cycle `ack` with the vector in `trap_vec`. The controller handles one event at a time.

Top module: `trap_entry_ctrl`

## Requirements
- R1: When an entry is taken, the save registers receive the IP, SP and FLG present in the cycle the request was accepted. `ack` is high in the following cycle and the values appear on `save_ip`, `save_sp` and `save_flg` at that time.
- R2: During an entry the read port presents the address `TABLE_BASE + 4*vector`. The default base is 0x400, and each table entry is one 32-bit word.
- R3: The handshake cycle is the cycle in which `rd_valid` and `rd_ready` are both high. In the cycle after the handshake, `ip_load` and `flg_load` pulse for one cycle and `new_ip` equals the read data; `sp_load` stays low.
- R4: On entry, `new_flg` equals the saved FLG with bit 17 (user mode) and bit 16 (interrupt enable) cleared. All other bits are unchanged.
- R5: A return command (`cmd_op` = 2) issued in supervisor mode produces one cycle in which `ip_load`, `sp_load` and `flg_load` are all high. In that cycle `new_ip`, `new_sp` and `new_flg` equal the three save registers.
- R6: Arbitration works as follows:
  - Exceptions win over commands, and commands win over external interrupts.
  - `exc_req` bit i requests vector i, for i from 0 to 5.
  - Among exceptions, the lowest set bit wins.
- R7: The system-call command (`cmd_op` = 1) always enters vector 6, in either mode.
- R8: In user mode (FLG bit 17 = 1), the software-interrupt command (0), return (2), set-enable (3) and clear-enable (4) commands each enter vector 4. In supervisor mode, the software-interrupt command enters the vector given on `cmd_vec`.
- R9: An external interrupt enters `ext_irq_vec` only while FLG bit 16 is set; otherwise it has no effect. Exception vector 1 is taken whatever the state of bit 16.
- R10: In supervisor mode, set-enable and clear-enable produce a lone `flg_load`. `new_flg` equals the current FLG with only bit 16 set or cleared, and the IP is not reloaded.
- R11: While busy, new requests are ignored. An unanswered read keeps `rd_valid` high with `rd_addr` and `trap_vec` steady until `rd_ready`.
- R12: After reset, `busy`, `ack`, `rd_valid`, all load strobes and all save registers are zero.
- R13: Command codes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | NUM_EXC | Exception requests, bit i for vector i |
| ext_irq_req | input | 1 | External interrupt request |
| ext_irq_vec | input | VW | External interrupt vector |
| cmd_valid | input | 1 | Software command present |
| cmd_op | input | 3 | 0 soft int, 1 syscall, 2 return, 3 set IE, 4 clear IE |
| cmd_vec | input | VW | Vector for the soft interrupt command |
| cur_ip | input | DW | Current instruction pointer |
| cur_sp | input | DW | Current stack pointer |
| cur_flg | input | DW | Current flags |
| rd_valid | output | 1 | Table read request |
| rd_addr | output | DW | Table read byte address |
| rd_ready | input | 1 | Read accepted, data on rd_data |
| rd_data | input | DW | Handler address read from the table |
| new_ip | output | DW | IP value for the core |
| new_sp | output | DW | SP value for the core |
| new_flg | output | DW | FLG value for the core |
| ip_load | output | 1 | Load strobe for new_ip |
| sp_load | output | 1 | Load strobe for new_sp |
| flg_load | output | 1 | Load strobe for new_flg |
| busy | output | 1 | A sequence is in progress |
| ack | output | 1 | One-cycle pulse when an entry is taken |
| trap_vec | output | VW | Vector of the latest entry |
| save_ip | output | DW | Save register holding IP |
| save_sp | output | DW | Save register holding SP |
| save_flg | output | DW | Save register holding FLG |

## Verification
The checker watches several rules on every cycle:
- the save registers match the inputs of the acceptance cycle, and the read address matches the reported vector;
- the handler address lands on `new_ip` after the handshake, and entry flags have bits 16 and 17 clear;
- a return reproduces the save registers, an enable change touches only bit 16, and a stalled read stays stable.

Arbitration order, vector selection for privileged commands in user mode, masking of external interrupts, and round trips through return can only be shown by the bench. It drives chosen request mixes and mode settings into a behavioural model and compares the two on every clock.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [2:0] {
        CMD_SOFTINT = 3'd0,
        CMD_SYSCALL = 3'd1,
        CMD_RETURN  = 3'd2,
        CMD_SETIE   = 3'd3,
        CMD_CLRIE   = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ENTER,
        ACT_RETURN,
        ACT_SETIE,
        ACT_CLRIE
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_APPLY
    } st_e;

    localparam int VEC_PROT    = 4;
    localparam int VEC_SYSCALL = 6;
    localparam int NUM_SAVE    = 3;
    localparam int SAVE_IP     = 0;
    localparam int SAVE_SP     = 1;
    localparam int SAVE_FLG    = 2;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int NUM_EXC = 6,
    parameter int VW      = 8
) (
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [VW-1:0]      cmd_vec,
    input  logic               ext_req,
    input  logic [VW-1:0]      ext_vec,
    input  logic               user_mode,
    input  logic               irq_en,
    output act_e               act,
    output logic [VW-1:0]      vec
);

    logic          exc_hit;
    logic [VW-1:0] exc_vec;

    // lowest numbered exception wins
    always_comb begin
        exc_hit = 1'b0;
        exc_vec = '0;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (exc_req[i]) begin
                exc_hit = 1'b1;
                exc_vec = VW'(i);
            end
        end
    end

    always_comb begin
        act = ACT_NONE;
        vec = '0;
        if (exc_hit) begin
            act = ACT_ENTER;
            vec = exc_vec;
        end else begin
            if (cmd_valid) begin
                case (cmd_e'(cmd_op))
                    CMD_SOFTINT: begin
                        act = ACT_ENTER;
                        vec = user_mode ? VW'(VEC_PROT) : cmd_vec;
                    end
                    CMD_SYSCALL: begin
                        act = ACT_ENTER;
                        vec = VW'(VEC_SYSCALL);
                    end
                    CMD_RETURN: begin
                        act = user_mode ? ACT_ENTER : ACT_RETURN;
                        vec = user_mode ? VW'(VEC_PROT) : '0;
                    end
                    CMD_SETIE: begin
                        act = user_mode ? ACT_ENTER : ACT_SETIE;
                        vec = user_mode ? VW'(VEC_PROT) : '0;
                    end
                    CMD_CLRIE: begin
                        act = user_mode ? ACT_ENTER : ACT_CLRIE;
                        vec = user_mode ? VW'(VEC_PROT) : '0;
                    end
                    default: act = ACT_NONE;
                endcase
            end
            if (act == ACT_NONE && ext_req && irq_en) begin
                act = ACT_ENTER;
                vec = ext_vec;
            end
        end
    end

endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank #(
    parameter int DW = 32,
    parameter int N  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [N-1:0][DW-1:0] wdata,
    output logic [N-1:0][DW-1:0] rdata
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [DW-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = we ? wdata[g] : slot_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign rdata[g] = slot_q;
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          VW         = 8,
    parameter int          NUM_EXC    = 6,
    parameter logic [31:0] TABLE_BASE = 32'h0000_0400,
    parameter int          IE_BIT     = 16,
    parameter int          UM_BIT     = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] exc_req,
    input  logic               ext_irq_req,
    input  logic [VW-1:0]      ext_irq_vec,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_op,
    input  logic [VW-1:0]      cmd_vec,
    input  logic [DW-1:0]      cur_ip,
    input  logic [DW-1:0]      cur_sp,
    input  logic [DW-1:0]      cur_flg,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_addr,
    input  logic               rd_ready,
    input  logic [DW-1:0]      rd_data,
    output logic [DW-1:0]      new_ip,
    output logic [DW-1:0]      new_sp,
    output logic [DW-1:0]      new_flg,
    output logic               ip_load,
    output logic               sp_load,
    output logic               flg_load,
    output logic               busy,
    output logic               ack,
    output logic [VW-1:0]      trap_vec,
    output logic [DW-1:0]      save_ip,
    output logic [DW-1:0]      save_sp,
    output logic [DW-1:0]      save_flg
);

    localparam logic [DW-1:0] IE_MASK    = DW'(1) << IE_BIT;
    localparam logic [DW-1:0] UM_MASK    = DW'(1) << UM_BIT;
    localparam logic [DW-1:0] ENTRY_KEEP = ~(IE_MASK | UM_MASK);
    localparam int            ENTRY_SH   = 2;

    typedef struct packed {
        st_e           st;
        logic          ack;
        logic [VW-1:0] vec;
        logic          rd_valid;
        logic [DW-1:0] addr;
        logic [DW-1:0] nip;
        logic [DW-1:0] nsp;
        logic [DW-1:0] nflg;
        logic          ld_ip;
        logic          ld_sp;
        logic          ld_flg;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    act_e                         sel_act;
    logic [VW-1:0]                sel_vec;
    logic                         save_we;
    logic [NUM_SAVE-1:0][DW-1:0]  save_wdata;
    logic [NUM_SAVE-1:0][DW-1:0]  save_rdata;

    trap_arbiter #(
        .NUM_EXC (NUM_EXC),
        .VW      (VW)
    ) u_arb (
        .exc_req   (exc_req),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_vec   (cmd_vec),
        .ext_req   (ext_irq_req),
        .ext_vec   (ext_irq_vec),
        .user_mode (cur_flg[UM_BIT]),
        .irq_en    (cur_flg[IE_BIT]),
        .act       (sel_act),
        .vec       (sel_vec)
    );

    always_comb begin
        save_wdata           = '0;
        save_wdata[SAVE_IP]  = cur_ip;
        save_wdata[SAVE_SP]  = cur_sp;
        save_wdata[SAVE_FLG] = cur_flg;
    end

    trap_save_bank #(
        .DW (DW),
        .N  (NUM_SAVE)
    ) u_save (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (save_we),
        .wdata (save_wdata),
        .rdata (save_rdata)
    );

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.ack = 1'b0;
        save_we    = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                case (sel_act)
                    ACT_ENTER: begin
                        save_we         = 1'b1;
                        ctrl_d.ack      = 1'b1;
                        ctrl_d.vec      = sel_vec;
                        ctrl_d.rd_valid = 1'b1;
                        ctrl_d.addr     = TABLE_BASE + (DW'(sel_vec) << ENTRY_SH);
                        ctrl_d.st       = ST_FETCH;
                    end
                    ACT_RETURN: begin
                        ctrl_d.nip    = save_rdata[SAVE_IP];
                        ctrl_d.nsp    = save_rdata[SAVE_SP];
                        ctrl_d.nflg   = save_rdata[SAVE_FLG];
                        ctrl_d.ld_ip  = 1'b1;
                        ctrl_d.ld_sp  = 1'b1;
                        ctrl_d.ld_flg = 1'b1;
                        ctrl_d.st     = ST_APPLY;
                    end
                    ACT_SETIE, ACT_CLRIE: begin
                        ctrl_d.nflg   = (sel_act == ACT_SETIE) ? (cur_flg | IE_MASK)
                                                               : (cur_flg & ~IE_MASK);
                        ctrl_d.ld_flg = 1'b1;
                        ctrl_d.st     = ST_APPLY;
                    end
                    default: ;
                endcase
            end
            ST_FETCH: begin
                if (rd_ready) begin
                    ctrl_d.rd_valid = 1'b0;
                    ctrl_d.nip      = rd_data;
                    ctrl_d.nflg     = save_rdata[SAVE_FLG] & ENTRY_KEEP;
                    ctrl_d.ld_ip    = 1'b1;
                    ctrl_d.ld_flg   = 1'b1;
                    ctrl_d.st       = ST_APPLY;
                end
            end
            ST_APPLY: begin
                ctrl_d.ld_ip  = 1'b0;
                ctrl_d.ld_sp  = 1'b0;
                ctrl_d.ld_flg = 1'b0;
                ctrl_d.st     = ST_IDLE;
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rd_valid = ctrl_q.rd_valid;
    assign rd_addr  = ctrl_q.addr;
    assign new_ip   = ctrl_q.nip;
    assign new_sp   = ctrl_q.nsp;
    assign new_flg  = ctrl_q.nflg;
    assign ip_load  = ctrl_q.ld_ip;
    assign sp_load  = ctrl_q.ld_sp;
    assign flg_load = ctrl_q.ld_flg;
    assign busy     = (ctrl_q.st != ST_IDLE);
    assign ack      = ctrl_q.ack;
    assign trap_vec = ctrl_q.vec;
    assign save_ip  = save_rdata[SAVE_IP];
    assign save_sp  = save_rdata[SAVE_SP];
    assign save_flg = save_rdata[SAVE_FLG];

endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
    parameter int          DW         = 32,
    parameter int          VW         = 8,
    parameter logic [31:0] TABLE_BASE = 32'h0000_0400,
    parameter int          IE_BIT     = 16,
    parameter int          UM_BIT     = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] cur_ip,
    input logic [DW-1:0] cur_sp,
    input logic [DW-1:0] cur_flg,
    input logic          rd_valid,
    input logic [DW-1:0] rd_addr,
    input logic          rd_ready,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] new_ip,
    input logic [DW-1:0] new_sp,
    input logic [DW-1:0] new_flg,
    input logic          ip_load,
    input logic          sp_load,
    input logic          flg_load,
    input logic          busy,
    input logic          ack,
    input logic [VW-1:0] trap_vec,
    input logic [DW-1:0] save_ip,
    input logic [DW-1:0] save_sp,
    input logic [DW-1:0] save_flg
);

    localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

    p_save_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (save_ip == $past(cur_ip) && save_sp == $past(cur_sp)
                 && save_flg == $past(cur_flg)));

    p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_addr == TABLE_BASE + (DW'(trap_vec) << 2));

    p_handler_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> (ip_load && flg_load && !sp_load
                                    && new_ip == $past(rd_data)));

    p_entry_flg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_load && !sp_load) |-> (flg_load && !new_flg[UM_BIT] && !new_flg[IE_BIT]));

    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> (ip_load && flg_load && new_ip == save_ip
                     && new_sp == save_sp && new_flg == save_flg));

    p_ie_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_load && !ip_load) |-> ((new_flg & ~IE_MASK) == ($past(cur_flg) & ~IE_MASK)));

    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr) && $stable(trap_vec)));

    p_ack_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (busy && rd_valid));

    p_one_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack, ip_load}));

endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(
    .DW         (DW),
    .VW         (VW),
    .TABLE_BASE (TABLE_BASE),
    .IE_BIT     (IE_BIT),
    .UM_BIT     (UM_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_ip   (cur_ip),
    .cur_sp   (cur_sp),
    .cur_flg  (cur_flg),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .new_ip   (new_ip),
    .new_sp   (new_sp),
    .new_flg  (new_flg),
    .ip_load  (ip_load),
    .sp_load  (sp_load),
    .flg_load (flg_load),
    .busy     (busy),
    .ack      (ack),
    .trap_vec (trap_vec),
    .save_ip  (save_ip),
    .save_sp  (save_sp),
    .save_flg (save_flg)
);

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;

    localparam logic [31:0] BASE = 32'h0000_0400;
    localparam logic [31:0] IE   = 32'h0001_0000;
    localparam logic [31:0] UM   = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  exc_req = '0;
    logic        ext_irq_req = 1'b0;
    logic [7:0]  ext_irq_vec = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_vec = '0;
    logic [31:0] cur_ip = '0, cur_sp = '0, cur_flg = '0;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data = '0;
    logic        rd_valid, ip_load, sp_load, flg_load, busy, ack;
    logic [31:0] rd_addr, new_ip, new_sp, new_flg, save_ip, save_sp, save_flg;
    logic [7:0]  trap_vec;

    int checks = 0;
    int failures = 0;
    int mem_wait = 0;
    int wcnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trap_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ext_irq_req(ext_irq_req),
        .ext_irq_vec(ext_irq_vec), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_vec(cmd_vec), .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flg(cur_flg),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .new_ip(new_ip), .new_sp(new_sp), .new_flg(new_flg), .ip_load(ip_load),
        .sp_load(sp_load), .flg_load(flg_load), .busy(busy), .ack(ack),
        .trap_vec(trap_vec), .save_ip(save_ip), .save_sp(save_sp), .save_flg(save_flg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] handler(input logic [31:0] a);
        return 32'hA000_0000 | ((a - BASE) << 2);
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_st;
    bit          m_ack, m_rdv, m_ldi, m_lds, m_ldf;
    logic [7:0]  m_vec;
    logic [31:0] m_addr, m_nip, m_nsp, m_nflg, m_s0, m_s1, m_s2;

    function automatic void decide(output int k, output int v);
        bit user;
        k = 0; v = 0;
        for (int i = 0; i < 6; i++) begin
            if (exc_req[i]) begin k = 1; v = i; return; end
        end
        user = cur_flg[17];
        if (cmd_valid) begin
            case (cmd_op)
                3'd0: begin k = 1; v = user ? 4 : int'(cmd_vec); end
                3'd1: begin k = 1; v = 6; end
                3'd2: if (user) begin k = 1; v = 4; end else k = 2;
                3'd3: if (user) begin k = 1; v = 4; end else k = 3;
                3'd4: if (user) begin k = 1; v = 4; end else k = 4;
                default: k = 0;
            endcase
            if (k != 0) return;
        end
        if (ext_irq_req && cur_flg[16]) begin k = 1; v = int'(ext_irq_vec); end
    endfunction

    always @(posedge clk) begin : model
        int k, v;
        if (!rst_n) begin
            m_st <= 0; m_ack <= 0; m_rdv <= 0; m_ldi <= 0; m_lds <= 0; m_ldf <= 0;
            m_vec <= 0; m_addr <= 0; m_nip <= 0; m_nsp <= 0; m_nflg <= 0;
            m_s0 <= 0; m_s1 <= 0; m_s2 <= 0;
        end else begin
            m_ack <= 0;
            if (m_st == 0) begin
                decide(k, v);
                if (k == 1) begin
                    m_s0 <= cur_ip; m_s1 <= cur_sp; m_s2 <= cur_flg;
                    m_ack <= 1; m_vec <= 8'(v); m_rdv <= 1;
                    m_addr <= BASE + 32'(v) * 4; m_st <= 1;
                end else if (k == 2) begin
                    m_nip <= m_s0; m_nsp <= m_s1; m_nflg <= m_s2;
                    m_ldi <= 1; m_lds <= 1; m_ldf <= 1; m_st <= 2;
                end else if (k == 3 || k == 4) begin
                    m_nflg <= (k == 3) ? (cur_flg | IE) : (cur_flg & ~IE);
                    m_ldf <= 1; m_st <= 2;
                end
            end else if (m_st == 1) begin
                if (rd_ready) begin
                    m_rdv <= 0; m_nip <= rd_data; m_nflg <= m_s2 & ~(IE | UM);
                    m_ldi <= 1; m_ldf <= 1; m_st <= 2;
                end
            end else begin
                m_ldi <= 0; m_lds <= 0; m_ldf <= 0; m_st <= 0;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check("R11 busy", 32'(busy), 32'(m_st != 0));
            check("R11 ack", 32'(ack), 32'(m_ack));
            check("R6 trap_vec", 32'(trap_vec), 32'(m_vec));
            check("R2 rd_valid", 32'(rd_valid), 32'(m_rdv));
            if (m_rdv) check("R2 rd_addr", rd_addr, m_addr);
            check("R3 ip_load", 32'(ip_load), 32'(m_ldi));
            check("R5 sp_load", 32'(sp_load), 32'(m_lds));
            check("R4 flg_load", 32'(flg_load), 32'(m_ldf));
            if (m_ldi) check("R3 new_ip", new_ip, m_nip);
            if (m_lds) check("R5 new_sp", new_sp, m_nsp);
            if (m_ldf) check("R4 new_flg", new_flg, m_nflg);
            check("R1 save_ip", save_ip, m_s0);
            check("R1 save_sp", save_sp, m_s1);
            check("R1 save_flg", save_flg, m_s2);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk);
        if (ip_load)  cur_ip  = new_ip;
        if (sp_load)  cur_sp  = new_sp;
        if (flg_load) cur_flg = new_flg;
        if (rd_valid) begin
            if (wcnt >= mem_wait) begin
                rd_ready = 1'b1;
                rd_data  = handler(rd_addr);
            end else begin
                rd_ready = 1'b0;
                wcnt++;
            end
        end else begin
            rd_ready = 1'b0;
            wcnt = 0;
        end
    endtask

    task automatic issue(input logic [5:0] exc, input bit ev, input logic [7:0] evec,
                         input bit cv, input logic [2:0] op, input logic [7:0] cvec,
                         output bit taken, output bit gack, output logic [7:0] gvec);
        taken = 0; gack = 0; gvec = 0;
        exc_req = exc; ext_irq_req = ev; ext_irq_vec = evec;
        cmd_valid = cv; cmd_op = op; cmd_vec = cvec;
        for (int i = 0; i < 3; i++) begin
            tick();
            if (busy) begin
                taken = 1; gack = ack; gvec = trap_vec;
                break;
            end
        end
        exc_req = '0; ext_irq_req = 0; cmd_valid = 0;
        for (int i = 0; i < 60; i++) begin
            if (!busy) break;
            tick();
        end
        tick();
    endtask

    bit          tk, ga;
    logic [7:0]  gv;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R12 reset state
        check("R12 busy", 32'(busy), 0);
        check("R12 rd_valid", 32'(rd_valid), 0);
        check("R12 ack", 32'(ack), 0);
        check("R12 loads", {29'd0, ip_load, sp_load, flg_load}, 0);
        check("R12 save", save_ip | save_sp | save_flg, 0);

        // R1/R3/R4: single exception in supervisor mode
        cur_ip = 32'h100; cur_sp = 32'h8000; cur_flg = IE | 32'h4;
        issue(6'b001000, 0, 0, 0, 0, 0, tk, ga, gv);
        check("R6 vec3", 32'(gv), 3);
        check("R1 ack", 32'(ga), 1);
        check("R3 ip", cur_ip, handler(BASE + 12));
        check("R4 flg", cur_flg, 32'h4);
        check("R1 save_ip", save_ip, 32'h100);
        check("R1 save_sp", save_sp, 32'h8000);
        check("R1 save_flg", save_flg, IE | 32'h4);

        // R5 return
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        check("R5 ip", cur_ip, 32'h100);
        check("R5 sp", cur_sp, 32'h8000);
        check("R5 flg", cur_flg, IE | 32'h4);

        // R6 exceptions, lowest wins over ext
        issue(6'b110100, 1, 8'h30, 0, 0, 0, tk, ga, gv);
        check("R6 lowest", 32'(gv), 2);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        // R7 syscall from user mode
        cur_flg = UM | IE;
        issue(0, 0, 0, 1, 3'd1, 8'h77, tk, ga, gv);
        check("R7 syscall", 32'(gv), 6);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        check("R5 back to user", cur_flg, UM | IE);

        // R8 privileged commands in user mode
        issue(0, 0, 0, 1, 3'd0, 8'h40, tk, ga, gv);
        check("R8 int user", 32'(gv), 4);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        check("R8 iret user", 32'(gv), 4);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        issue(0, 0, 0, 1, 3'd3, 0, tk, ga, gv);
        check("R8 sif user", 32'(gv), 4);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        issue(0, 0, 0, 1, 3'd4, 0, tk, ga, gv);
        check("R8 cif user", 32'(gv), 4);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        // R8 supervisor soft interrupt uses cmd_vec
        cur_flg = IE;
        issue(0, 0, 0, 1, 3'd0, 8'h40, tk, ga, gv);
        check("R8 int sup", 32'(gv), 32'h40);
        check("R2 handler", cur_ip, handler(BASE + 32'h100));
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        // R9 masking
        cur_flg = 32'h0; cur_ip = 32'h220;
        issue(0, 1, 8'h21, 0, 0, 0, tk, ga, gv);
        check("R9 masked", 32'(tk), 0);
        check("R9 masked ip", cur_ip, 32'h220);
        issue(6'b000010, 0, 0, 0, 0, 0, tk, ga, gv);
        check("R9 nmi", 32'(gv), 1);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        cur_flg = IE;
        issue(0, 1, 8'h21, 0, 0, 0, tk, ga, gv);
        check("R9 ext", 32'(gv), 32'h21);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        // R10 enable set/clear
        cur_flg = 32'h4; cur_ip = 32'h300;
        issue(0, 0, 0, 1, 3'd3, 0, tk, ga, gv);
        check("R10 sif", cur_flg, IE | 32'h4);
        check("R10 ip kept", cur_ip, 32'h300);
        issue(0, 0, 0, 1, 3'd4, 0, tk, ga, gv);
        check("R10 cif", cur_flg, 32'h4);

        // R13 unused command codes
        for (int op = 5; op < 8; op++) begin
            issue(0, 0, 0, 1, 3'(op), 0, tk, ga, gv);
            check("R13 ignored", 32'(tk), 0);
        end
        check("R13 flg", cur_flg, 32'h4);

        // R6 command beats ext, exception beats command
        cur_flg = IE;
        issue(0, 1, 8'h22, 1, 3'd0, 8'h50, tk, ga, gv);
        check("R6 cmd over ext", 32'(gv), 32'h50);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);
        issue(6'b000001, 0, 0, 1, 3'd1, 0, tk, ga, gv);
        check("R6 exc over cmd", 32'(gv), 0);
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        // R11 slow memory
        mem_wait = 4;
        issue(6'b100000, 0, 0, 0, 0, 0, tk, ga, gv);
        check("R11 vec5", 32'(gv), 5);
        check("R11 handler", cur_ip, handler(BASE + 20));
        mem_wait = 0;
        issue(0, 0, 0, 1, 3'd2, 0, tk, ga, gv);

        repeat (3) tick();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule